// File: doc/BRIEF.md
# Debug Access Bus Bridge

This block carries sized read and write requests from a debug-port clock domain to an internal service bus that runs on the system clock. The debugger presents a 36-bit address, an access size and write data. The top four address bits name a target slave, and the low 32 bits are the slave-local address. The bridge screens out requests it cannot serve and answers those with an error at once. Each request it accepts crosses into the system domain through a toggle handshake, runs as one transfer on a single-outstanding slave bus, and returns its status and right-aligned read data to the debug side.

The system clock may be gated while the device sleeps. A request that must reach the bus raises a clock-request output, which keeps that clock running until the response is back in the debug domain. This output does not wake the processor. A free-running measurement reports how many system clock edges fall within each window of 256 debug clocks. A debugger can use that count to pace its transfers.

Top module: `dbg_sab_bridge`

## Requirements
- R1: An accepted request to slave 0x1 or 0x4 with a legal, aligned size produces exactly one slave-bus transfer. In that transfer `busSlave` equals address bits 35:32, `busAddr` equals bits 31:0 and `busWrite` follows the request.
- R2: A request whose address bits 35:32 are anything other than 0x1 or 0x4 produces no slave-bus transfer. It gets a response with `rspErr`=1 and `rspRdata`=0.
- R3: Size code 0 is a byte, 1 a halfword, 2 a word, and 3 is reserved. A reserved size, a halfword with address bit 0 set, or a word with address bits 1:0 not both zero is rejected with `rspErr`=1 and produces no transfer.
- R4: `busByteEn` is 4'b0001 shifted left by address bits 1:0 for a byte, 4'b0011 shifted left by the same amount for a halfword, and 4'b1111 for a word. Right-aligned write data is moved to those lanes, lane k being bits 8k+7:8k, and all other lanes are zero.
- R5: For a read, the selected byte or halfword of `busRdata` comes back in the low bits of `rspRdata`, and every bit above it is zero.
- R6: A slave that completes with `busErr`=1 yields `rspErr`=1. A completion without it yields `rspErr`=0.
- R7: `busy` rises on the clock after a request is accepted. It stays high through the response cycle. `reqValid` is ignored while `busy` is high: it causes no transfer and no extra response.
- R8: Each accepted request gets exactly one `rspValid` pulse, one debug clock long. A rejected request gets its pulse on the clock after acceptance.
- R9: `sysClkReq` rises on the clock after a bus-bound request is accepted and falls with the response. A rejected request leaves it low.
- R10: `ratioCount` holds the number of system clock rising edges counted over the last complete window of 256 debug clocks, within ±2. It is 0 while the system clock is stopped.
- R11: `busValid` stays high until the slave returns `busReady`. While it waits, address, lane enables and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dbgClk | input | 1 | Debug-port clock |
| dbgRstN | input | 1 | Debug-domain reset, active low |
| sysClk | input | 1 | System clock, may be gated |
| sysRstN | input | 1 | System-domain reset, active low |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 36 | Slave number [35:32] and local address [31:0] |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| reqWdata | input | 32 | Right-aligned write data |
| busy | output | 1 | A request is in flight |
| rspValid | output | 1 | One-cycle response strobe |
| rspErr | output | 1 | Response error flag |
| rspRdata | output | 32 | Right-aligned read data |
| sysClkReq | output | 1 | Asks for the system clock to run |
| ratioCount | output | 16 | System edges per 256 debug clocks |
| busValid | output | 1 | Slave-bus transfer request |
| busSlave | output | 4 | Target slave number |
| busAddr | output | 32 | Slave-local address |
| busWrite | output | 1 | Transfer direction |
| busByteEn | output | 4 | Byte lane enables |
| busWdata | output | 32 | Lane-placed write data |
| busReady | input | 1 | Slave completes the transfer |
| busRdata | input | 32 | Slave read data |
| busErr | input | 1 | Slave error on completion |

## Verification
A wrong decode or alignment check shows up one debug clock after acceptance. Either a stray transfer appears on the slave bus, or an error pulse arrives where a data response belonged, so a sweep over every slave number, size code and low address pair catches it. A lost or doubled handshake toggle shows within a few system clocks. Either a second transfer or a second response appears, or `busy` never clears, and the bench's response timeout exposes that. A bad lane shift or read alignment appears in the very response of the affected access. A clock request that falls too early leaves the access stalled while the system clock is gated.

// File: rtl/dbgbr_pkg.sv
package dbgbr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // strobes from control to datapath, debug domain
  typedef struct packed {
    logic capture;
    logic localReject;
    logic deliver;
  } dbgStrobe_t;

  // strobes from control to datapath, system domain
  typedef struct packed {
    logic complete;
  } sysStrobe_t;

  localparam logic [3:0] SLV_DEBUG = 4'h1;
  localparam logic [3:0] SLV_MEM   = 4'h4;

endpackage

// File: rtl/dbgbr_ratio.sv
module dbgbr_ratio #(
  parameter int CNT_W    = 16,
  parameter int WIN_LOG2 = 8
) (
  input  logic             dbgClk,
  input  logic             dbgRstN,
  input  logic             sysClk,
  input  logic             sysRstN,
  output logic [CNT_W-1:0] ratioCount
);

  logic [CNT_W-1:0]    sysBin, sysGray, grayS1, grayS2, curBin, lastBin;
  logic [WIN_LOG2-1:0] winCnt;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      sysBin  <= '0;
      sysGray <= '0;
    end else begin
      sysBin  <= sysBin + 1'b1;
      sysGray <= sysBin ^ (sysBin >> 1);
    end
  end

  always_comb begin
    curBin[CNT_W-1] = grayS2[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) curBin[i] = curBin[i+1] ^ grayS2[i];
  end

  always_ff @(posedge dbgClk or negedge dbgRstN) begin
    if (!dbgRstN) begin
      grayS1     <= '0;
      grayS2     <= '0;
      winCnt     <= '0;
      lastBin    <= '0;
      ratioCount <= '0;
    end else begin
      grayS1 <= sysGray;
      grayS2 <= grayS1;
      winCnt <= winCnt + 1'b1;
      if (winCnt == '1) begin
        ratioCount <= curBin - lastBin;
        lastBin    <= curBin;
      end
    end
  end

endmodule

// File: rtl/dbgbr_ctrl.sv
module dbgbr_ctrl
  import dbgbr_pkg::*;
(
  input  logic       dbgClk,
  input  logic       dbgRstN,
  input  logic       sysClk,
  input  logic       sysRstN,
  input  logic       reqValid,
  input  logic       reqReject,
  output dbgStrobe_t dbgStb,
  output sysStrobe_t sysStb,
  output logic       busy,
  output logic       rspValid,
  output logic       sysClkReq,
  input  logic       busReady,
  output logic       busValid
);

  logic       reqTog, ackTog;
  logic [2:0] reqSync, ackSync;
  logic       accept, ackSeen, launch;

  assign accept  = reqValid && !busy;
  assign ackSeen = ackSync[2] ^ ackSync[1];
  assign launch  = reqSync[2] ^ reqSync[1];

  always_comb begin
    dbgStb.capture     = accept;
    dbgStb.localReject = accept && reqReject;
    dbgStb.deliver     = ackSeen;
    sysStb.complete    = busValid && busReady;
  end

  // debug domain: accept, launch toggle, response
  always_ff @(posedge dbgClk or negedge dbgRstN) begin
    if (!dbgRstN) begin
      busy      <= 1'b0;
      rspValid  <= 1'b0;
      sysClkReq <= 1'b0;
      reqTog    <= 1'b0;
      ackSync   <= '0;
    end else begin
      ackSync  <= {ackSync[1:0], ackTog};
      rspValid <= (accept && reqReject) || ackSeen;
      if (accept) begin
        busy <= 1'b1;
        if (!reqReject) begin
          reqTog    <= ~reqTog;
          sysClkReq <= 1'b1;
        end
      end else if (rspValid) begin
        busy <= 1'b0;
      end
      if (ackSeen) sysClkReq <= 1'b0;
    end
  end

  // system domain: pick up toggle, run one bus transfer, toggle back
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      reqSync  <= '0;
      busValid <= 1'b0;
      ackTog   <= 1'b0;
    end else begin
      reqSync <= {reqSync[1:0], reqTog};
      if (launch) begin
        busValid <= 1'b1;
      end else if (busValid && busReady) begin
        busValid <= 1'b0;
        ackTog   <= ~ackTog;
      end
    end
  end

  assert_pulse_R8: assert property (@(posedge dbgClk) disable iff (!dbgRstN)
    rspValid |=> !rspValid);

  assert_clkreq_R9: assert property (@(posedge dbgClk) disable iff (!dbgRstN)
    sysClkReq |-> busy);

  assert_single_R7: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (busValid && busReady) |=> !busValid);

endmodule

// File: rtl/dbgbr_datapath.sv
module dbgbr_datapath
  import dbgbr_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int SLV_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                  dbgClk,
  input  logic                  dbgRstN,
  input  logic                  sysClk,
  input  logic                  sysRstN,
  input  dbgStrobe_t            dbgStb,
  input  sysStrobe_t            sysStb,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [1:0]            reqSize,
  input  logic [DATA_W-1:0]     reqWdata,
  output logic                  reqReject,
  output logic                  rspErr,
  output logic [DATA_W-1:0]     rspRdata,
  output logic [SLV_W-1:0]      busSlave,
  output logic [ADDR_W-SLV_W-1:0] busAddr,
  output logic                  busWrite,
  output logic [DATA_W/8-1:0]   busByteEn,
  output logic [DATA_W-1:0]     busWdata,
  input  logic [DATA_W-1:0]     busRdata,
  input  logic                  busErr
);

  localparam int LOC_W = ADDR_W - SLV_W;
  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] capAddr;
  accSize_e          capSize, inSize;
  logic              capWrite;
  logic [DATA_W-1:0] capWdata, wdMasked, rdShift, rdAligned, sysRdata;
  logic              sysErr;
  logic [1:0]        laneOff;
  logic [SLV_W-1:0]  inSlave;
  logic              slaveBad, misaligned;

  // request screening
  assign inSize  = accSize_e'(reqSize);
  assign inSlave = reqAddr[ADDR_W-1 -: SLV_W];
  assign slaveBad   = !(inSlave == SLV_DEBUG || inSlave == SLV_MEM);
  assign misaligned = (inSize == SZ_HALF && reqAddr[0]) ||
                      (inSize == SZ_WORD && reqAddr[1:0] != 2'b00);
  assign reqReject  = slaveBad || misaligned || (inSize == SZ_RSVD);

  // captured request drives the bus; held for the whole transaction
  assign laneOff  = capAddr[1:0];
  assign busSlave = capAddr[ADDR_W-1 -: SLV_W];
  assign busAddr  = capAddr[LOC_W-1:0];
  assign busWrite = capWrite;

  always_comb begin
    case (capSize)
      SZ_BYTE: begin
        busByteEn = LANES'(1) << laneOff;
        wdMasked  = {{(DATA_W-8){1'b0}}, capWdata[7:0]};
      end
      SZ_HALF: begin
        busByteEn = LANES'(3) << laneOff;
        wdMasked  = {{(DATA_W-16){1'b0}}, capWdata[15:0]};
      end
      default: begin
        busByteEn = '1;
        wdMasked  = capWdata;
      end
    endcase
  end
  assign busWdata = wdMasked << {laneOff, 3'b000};

  assign rdShift = busRdata >> {laneOff, 3'b000};
  always_comb begin
    case (capSize)
      SZ_BYTE: rdAligned = {{(DATA_W-8){1'b0}}, rdShift[7:0]};
      SZ_HALF: rdAligned = {{(DATA_W-16){1'b0}}, rdShift[15:0]};
      default: rdAligned = rdShift;
    endcase
  end

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      sysRdata <= '0;
      sysErr   <= 1'b0;
    end else if (sysStb.complete) begin
      sysRdata <= rdAligned;
      sysErr   <= busErr;
    end
  end

  always_ff @(posedge dbgClk or negedge dbgRstN) begin
    if (!dbgRstN) begin
      capAddr  <= '0;
      capSize  <= SZ_WORD;
      capWrite <= 1'b0;
      capWdata <= '0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      if (dbgStb.capture) begin
        capAddr  <= reqAddr;
        capSize  <= inSize;
        capWrite <= reqWrite;
        capWdata <= reqWdata;
      end
      if (dbgStb.localReject) begin
        rspErr   <= 1'b1;
        rspRdata <= '0;
      end else if (dbgStb.deliver) begin
        rspErr   <= sysErr;
        rspRdata <= sysRdata;
      end
    end
  end

  assert_reject_R3: assert property (@(posedge dbgClk) disable iff (!dbgRstN)
    dbgStb.localReject |=> (rspErr && rspRdata == '0));

endmodule

// File: rtl/dbg_sab_bridge.sv
module dbg_sab_bridge
  import dbgbr_pkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int SLV_W    = 4,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int WIN_LOG2 = 8
) (
  input  logic                    dbgClk,
  input  logic                    dbgRstN,
  input  logic                    sysClk,
  input  logic                    sysRstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [1:0]              reqSize,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic                    busy,
  output logic                    rspValid,
  output logic                    rspErr,
  output logic [DATA_W-1:0]       rspRdata,
  output logic                    sysClkReq,
  output logic [CNT_W-1:0]        ratioCount,
  output logic                    busValid,
  output logic [SLV_W-1:0]        busSlave,
  output logic [ADDR_W-SLV_W-1:0] busAddr,
  output logic                    busWrite,
  output logic [DATA_W/8-1:0]     busByteEn,
  output logic [DATA_W-1:0]       busWdata,
  input  logic                    busReady,
  input  logic [DATA_W-1:0]       busRdata,
  input  logic                    busErr
);

  dbgStrobe_t dbgStb;
  sysStrobe_t sysStb;
  logic       reqReject;

  dbgbr_ctrl u_ctrl (
    .dbgClk(dbgClk), .dbgRstN(dbgRstN), .sysClk(sysClk), .sysRstN(sysRstN),
    .reqValid(reqValid), .reqReject(reqReject),
    .dbgStb(dbgStb), .sysStb(sysStb),
    .busy(busy), .rspValid(rspValid), .sysClkReq(sysClkReq),
    .busReady(busReady), .busValid(busValid)
  );

  dbgbr_datapath #(.ADDR_W(ADDR_W), .SLV_W(SLV_W), .DATA_W(DATA_W)) u_dp (
    .dbgClk(dbgClk), .dbgRstN(dbgRstN), .sysClk(sysClk), .sysRstN(sysRstN),
    .dbgStb(dbgStb), .sysStb(sysStb),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .reqReject(reqReject), .rspErr(rspErr), .rspRdata(rspRdata),
    .busSlave(busSlave), .busAddr(busAddr), .busWrite(busWrite),
    .busByteEn(busByteEn), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr)
  );

  dbgbr_ratio #(.CNT_W(CNT_W), .WIN_LOG2(WIN_LOG2)) u_ratio (
    .dbgClk(dbgClk), .dbgRstN(dbgRstN), .sysClk(sysClk), .sysRstN(sysRstN),
    .ratioCount(ratioCount)
  );

  assert_hold_R11: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) &&
                                 $stable(busByteEn) && $stable(busWdata)));

  assert_slave_R2: assert property (@(posedge sysClk) disable iff (!sysRstN)
    busValid |-> (busSlave == SLV_DEBUG || busSlave == SLV_MEM));

  assert_lanes_R4: assert property (@(posedge sysClk) disable iff (!sysRstN)
    busValid |-> ($countones(busByteEn) == 1 || busByteEn == 4'b0011 ||
                  busByteEn == 4'b1100 || busByteEn == 4'b1111));

endmodule

// File: tb/dbg_sab_bridge_bench.sv
`timescale 1ns/1ps
module dbg_sab_bridge_bench;

  logic        dbgClk = 1'b0, rawSys = 1'b0, gateEn = 1'b0, awake = 1'b1;
  logic        dbgRstN = 1'b0, sysRstN = 1'b0;
  logic        sysClk;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [35:0] reqAddr = '0;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] reqWdata = '0;
  logic        busy, rspValid, rspErr, sysClkReq;
  logic [31:0] rspRdata;
  logic [15:0] ratioCount;
  logic        busValid, busWrite;
  logic [3:0]  busSlave, busByteEn;
  logic [31:0] busAddr, busWdata, busRdata;
  logic        busReady, busErr;

  int checks = 0, fails = 0;
  bit done = 0;
  int xfers = 0, rspCount = 0;
  logic [3:0]  lastSlave, lastBe;
  logic [31:0] lastAddr, lastWdata;
  logic        lastWrite;
  logic        rErr, rGot;
  logic [31:0] rData;

  always #10 dbgClk = ~dbgClk;           // 50 MHz
  initial begin #7; forever #15 rawSys = ~rawSys; end
  always @(negedge rawSys) gateEn <= awake || sysClkReq;
  assign sysClk = rawSys & gateEn;

  dbg_sab_bridge u_dbg_sab_bridge (
    .dbgClk(dbgClk), .dbgRstN(dbgRstN), .sysClk(sysClk), .sysRstN(sysRstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWdata(reqWdata), .busy(busy), .rspValid(rspValid), .rspErr(rspErr),
    .rspRdata(rspRdata), .sysClkReq(sysClkReq), .ratioCount(ratioCount),
    .busValid(busValid), .busSlave(busSlave), .busAddr(busAddr), .busWrite(busWrite),
    .busByteEn(busByteEn), .busWdata(busWdata), .busReady(busReady),
    .busRdata(busRdata), .busErr(busErr)
  );

  function automatic logic [31:0] modelWord(input logic [3:0] s, input logic [31:0] a);
    return {s, a[29:2] ^ 28'h5A5_A5A5};
  endfunction

  // slave model: ready one cycle after valid, error on the top word
  assign busRdata = modelWord(busSlave, busAddr);
  assign busErr   = (busAddr[31:2] == 30'h3FFF_FFFF);
  always @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) busReady <= 1'b0;
    else begin
      busReady <= busValid && !busReady;
      if (busValid && busReady) begin
        xfers     <= xfers + 1;
        lastSlave <= busSlave;
        lastAddr  <= busAddr;
        lastBe    <= busByteEn;
        lastWdata <= busWdata;
        lastWrite <= busWrite;
      end
    end
  end
  always @(posedge dbgClk) if (rspValid) rspCount <= rspCount + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic waitRsp();
    rGot = 0;
    for (int i = 0; i < 400 && !rGot; i++) begin
      if (rspValid) begin rGot = 1; rErr = rspErr; rData = rspRdata; end
      else @(negedge dbgClk);
    end
    chkEq("R8 response arrives", 64'(rGot), 64'd1);
    @(negedge dbgClk);
    chkEq("R8 response is one cycle", 64'(rspValid), 64'd0);
    while (busy) @(negedge dbgClk);
  endtask

  task automatic access(input logic w, input logic [35:0] a, input logic [1:0] sz, input logic [31:0] wd);
    @(negedge dbgClk);
    reqValid = 1; reqWrite = w; reqAddr = a; reqSize = sz; reqWdata = wd;
    @(negedge dbgClk);
    reqValid = 0;
    waitRsp();
  endtask

  function automatic bit rejectOf(input int slv, input int sz, input int lo);
    return !(slv == 1 || slv == 4) || sz == 3 || (sz == 1 && lo[0]) || (sz == 2 && lo != 0);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge dbgClk);
    dbgRstN = 1; sysRstN = 1;
    @(negedge dbgClk);
    // reset state
    chkEq("R7 busy after reset", 64'(busy), 64'd0);
    chkEq("R8 rspValid after reset", 64'(rspValid), 64'd0);
    chkEq("R9 sysClkReq after reset", 64'(sysClkReq), 64'd0);
    chkEq("R11 busValid after reset", 64'(busValid), 64'd0);

    // read sweep over every slave, size and low address pair
    for (int slv = 0; slv < 16; slv++)
      for (int sz = 0; sz < 4; sz++)
        for (int lo = 0; lo < 4; lo++) begin
          automatic logic [31:0] la = 32'h0012_3450 + 32'(slv << 8) + 32'(lo);
          automatic int x0 = xfers;
          automatic bit rej = rejectOf(slv, sz, lo);
          automatic logic [31:0] w = modelWord(4'(slv), la) >> (lo * 8);
          automatic logic [31:0] exp = (sz == 0) ? (w & 32'hFF) : (sz == 1) ? (w & 32'hFFFF) : w;
          access(1'b0, {4'(slv), la}, 2'(sz), 32'h0);
          if (rej) begin
            chkEq("R2 R3 reject err", 64'(rErr), 64'd1);
            chkEq("R2 R3 no transfer", 64'(xfers - x0), 64'd0);
            chkEq("R2 reject data zero", 64'(rData), 64'd0);
          end else begin
            chkEq("R1 one transfer", 64'(xfers - x0), 64'd1);
            chkEq("R1 slave field", 64'(lastSlave), 64'(slv));
            chkEq("R1 local addr", 64'(lastAddr), 64'(la));
            chkEq("R6 no error", 64'(rErr), 64'd0);
            chkEq("R5 read aligned", 64'(rData), 64'(exp));
          end
        end

    // write lane placement
    for (int s = 0; s < 2; s++)
      for (int sz = 0; sz < 3; sz++)
        for (int lo = 0; lo < 4; lo++) begin
          automatic int slv = (s == 0) ? 1 : 4;
          automatic logic [31:0] wd = 32'hC3D2_E1F0 ^ 32'(lo);
          automatic logic [3:0] expBe = (sz == 0) ? 4'(1 << lo) : (sz == 1) ? 4'(3 << lo) : 4'hF;
          automatic logic [31:0] expWd = (sz == 0) ? ((wd & 32'hFF) << (lo * 8)) :
                                         (sz == 1) ? ((wd & 32'hFFFF) << (lo * 8)) : wd;
          if (!rejectOf(slv, sz, lo)) begin
            access(1'b1, {4'(slv), 32'h0000_8000 + 32'(lo)}, 2'(sz), wd);
            chkEq("R1 write flag", 64'(lastWrite), 64'd1);
            chkEq("R4 byte enables", 64'(lastBe), 64'(expBe));
            chkEq("R4 lane data", 64'(lastWdata), 64'(expWd));
          end
        end

    // slave error
    access(1'b0, 36'h4_FFFF_FFFC, 2'd2, 32'h0);
    chkEq("R6 slave error", 64'(rErr), 64'd1);

    // busy: further requests ignored
    begin
      automatic int x0 = xfers, r0 = rspCount;
      @(negedge dbgClk);
      reqValid = 1; reqWrite = 0; reqAddr = 36'h1_0000_0100; reqSize = 2'd2;
      @(negedge dbgClk);
      reqAddr = 36'h4_0000_0200;
      chkEq("R7 busy after accept", 64'(busy), 64'd1);
      repeat (2) @(negedge dbgClk);
      chkEq("R7 still busy", 64'(busy), 64'd1);
      reqValid = 0;
      waitRsp();
      repeat (20) @(negedge dbgClk);
      chkEq("R7 one transfer", 64'(xfers - x0), 64'd1);
      chkEq("R7 one response", 64'(rspCount - r0), 64'd1);
      chkEq("R7 first address kept", 64'(lastAddr), 64'h100);
    end

    // gated system clock
    awake = 0;
    repeat (4) @(negedge dbgClk);
    chkEq("R9 idle no clock request", 64'(sysClkReq), 64'd0);
    @(negedge dbgClk);
    reqValid = 1; reqWrite = 0; reqAddr = 36'h4_0000_0044; reqSize = 2'd2;
    @(negedge dbgClk);
    reqValid = 0;
    chkEq("R9 clock request raised", 64'(sysClkReq), 64'd1);
    rGot = 0;
    for (int i = 0; i < 400 && !rGot; i++) begin
      if (rspValid) begin rGot = 1; rErr = rspErr; rData = rspRdata; end
      else begin
        chkEq("R9 held until response", 64'(sysClkReq), 64'd1);
        @(negedge dbgClk);
      end
    end
    chkEq("R9 gated access completes", 64'(rGot), 64'd1);
    chkEq("R9 clock request dropped", 64'(sysClkReq), 64'd0);
    chkEq("R9 gated read data", 64'(rData), 64'(modelWord(4'h4, 32'h44)));
    while (busy) @(negedge dbgClk);
    @(negedge dbgClk);
    reqValid = 1; reqAddr = 36'h2_0000_0000; reqSize = 2'd2;
    @(negedge dbgClk);
    reqValid = 0;
    chkEq("R9 reject leaves request low", 64'(sysClkReq), 64'd0);
    chkEq("R8 reject responds next cycle", 64'(rspValid), 64'd1);
    while (busy) @(negedge dbgClk);

    // ratio measurement: stopped, then running
    repeat (3 * 256) @(negedge dbgClk);
    chkEq("R10 ratio while gated", 64'(ratioCount), 64'd0);
    awake = 1;
    repeat (3 * 256) @(negedge dbgClk);
    chk(ratioCount >= 16'd168 && ratioCount <= 16'd173, "R10 ratio running",
        64'(ratioCount), 64'd171);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule